// File: doc/BRIEF.md
# I2C SCL Split-Divisor Clock Generator

This block derives the SCL timing base of an I2C master from the peripheral clock. One divider register carries two fields: one sets the length of the low phase of SCL and the other sets the length of the high phase. Each field counts in units of eight peripheral-clock cycles, with one unit added. The whole period is therefore `8 * ((lo + 1) + (hi + 1))` cycles. When the two fields differ by one, the high and low phases differ by eight cycles. Software converts a target bus rate into the two fields. Setting both fields to zero gives the fastest bus, one sixteenth of the peripheral clock.

The block drives the SCL level, with 1 meaning released and 0 meaning pulled low. It pulses a strobe when SCL falls and another when SCL is released. It also pulses a mid-phase strobe in each phase. A bus engine uses the low-phase mid strobe to change SDA and the high-phase mid strobe to sample it. The high-phase count only advances while the SCL wire is seen high, so a target that stretches the clock lengthens the high phase. A divider written during a transfer first applies at the next falling edge of SCL.

Top module: `scl_divgen`

## Requirements
- R1: The divider register resets to 0. A write (`div_we`) is visible on `div_rdata` from the next cycle. The low-phase field occupies bits [DW-1:0] and the high-phase field occupies bits [2*DW-1:DW].
- R2: The low phase of SCL lasts exactly 8*(lo+1) cycles, counted from the cycle of `fall_stb` to the cycle of `rise_stb`.
- R3: Without stretching, the high phase lasts exactly 8*(hi+1) cycles, counted from `rise_stb` to the next `fall_stb`.
- R4: `lo_mid_stb` pulses once per low phase, 4*(lo+1) cycles after `fall_stb`.
- R5: Without stretching, `hi_mid_stb` pulses once per high phase, 4*(hi+1) cycles after `rise_stb`.
- R6: The divider fields are latched only when SCL falls. A write during a period leaves that period unchanged and governs the next one.
- R7: The high-phase count advances only in cycles where `scl_in` is 1. Every cycle with `scl_in` low delays the high-mid strobe and the end of the high phase by one cycle.
- R8: One cycle after `enable` is seen low, `scl_o` is 1 and no strobe fires. This holds for as long as `enable` stays low, including when it drops mid-phase.
- R9: One cycle after `enable` is first seen high, `scl_o` goes to 0 and `fall_stb` pulses.
- R10: After reset, `scl_o` is 1, all strobes are 0 and `div_rdata` is 0.
- R11: `fall_stb` fires only in the first cycle of SCL low, and `rise_stb` fires only in the first cycle of SCL released. At most one strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low holds the counters idle and releases SCL |
| div_we | input | 1 | Divider register write strobe |
| div_wdata | input | 2*DW | Divider value: {high field, low field} |
| div_rdata | output | 2*DW | Divider register readback |
| scl_in | input | 1 | Sampled level of the SCL wire |
| scl_o | output | 1 | SCL drive: 1 released, 0 pulled low |
| fall_stb | output | 1 | First cycle of SCL low |
| rise_stb | output | 1 | First cycle of SCL released |
| lo_mid_stb | output | 1 | Midpoint of the low phase (SDA change point) |
| hi_mid_stb | output | 1 | Midpoint of the high phase (SDA sample point) |

## Verification
A wrong phase counter or a wrong latched field appears at the ports within the period it corrupts. The spacing between `fall_stb`, `lo_mid_stb`, `rise_stb`, `hi_mid_stb` and the next `fall_stb` moves by a multiple of a cycle, so each finished period is compared against lengths computed from the written fields. Latching at the wrong moment only shows in the period that straddles a register write, so the bench writes new fields in the middle of a low phase. A stretch-handling fault only shows when `scl_in` is held low while SCL is released, so the bench holds it low for a known number of cycles. An idle-state fault shows one cycle after `enable` falls, as SCL held low or a stray strobe.

// File: rtl/scl_divgen.sv
module scl_divgen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          div_we,
  input  logic [2*DW-1:0] div_wdata,
  output logic [2*DW-1:0] div_rdata,
  input  logic          scl_in,
  output logic          scl_o,
  output logic          fall_stb,
  output logic          rise_stb,
  output logic          lo_mid_stb,
  output logic          hi_mid_stb
);
  localparam int CW = DW + 3;

  logic [2*DW-1:0] div_q;
  logic [DW-1:0]   lo_act, hi_act;
  logic [CW-1:0]   cnt;
  logic            run, phase_hi, fall_q, rise_q;

  wire [CW-1:0] lo_end = {lo_act, 3'b111};
  wire [CW-1:0] hi_end = {hi_act, 3'b111};
  wire [CW-1:0] lo_mid = CW'({lo_act, 2'b00}) + CW'(4);
  wire [CW-1:0] hi_mid = CW'({hi_act, 2'b00}) + CW'(4);
  wire          hi_done = phase_hi && scl_in && (cnt == hi_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      lo_act   <= '0;
      hi_act   <= '0;
      cnt      <= '0;
      run      <= 1'b0;
      phase_hi <= 1'b1;
      fall_q   <= 1'b0;
      rise_q   <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      rise_q <= 1'b0;
      if (div_we) div_q <= div_wdata;
      if (!enable) begin
        run      <= 1'b0;
        phase_hi <= 1'b1;
        cnt      <= '0;
      end else if (!run || hi_done) begin
        run      <= 1'b1;
        phase_hi <= 1'b0;
        cnt      <= '0;
        lo_act   <= div_q[DW-1:0];
        hi_act   <= div_q[2*DW-1:DW];
        fall_q   <= 1'b1;
      end else if (!phase_hi) begin
        if (cnt == lo_end) begin
          phase_hi <= 1'b1;
          cnt      <= '0;
          rise_q   <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (scl_in) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign div_rdata  = div_q;
  assign scl_o      = phase_hi;
  assign fall_stb   = fall_q;
  assign rise_stb   = rise_q;
  assign lo_mid_stb = run && !phase_hi && (cnt == lo_mid);
  assign hi_mid_stb = run && phase_hi && scl_in && (cnt == hi_mid);
endmodule

// File: rtl/scl_divgen_chk.sv
module scl_divgen_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            div_we,
  input logic [2*DW-1:0] div_wdata,
  input logic [2*DW-1:0] div_rdata,
  input logic            scl_in,
  input logic            scl_o,
  input logic            fall_stb,
  input logic            rise_stb,
  input logic            lo_mid_stb,
  input logic            hi_mid_stb
);
  logic [2*DW-1:0] rd_d1;
  logic [DW-1:0]   lat_lo;
  logic [DW+3:0]   lo_run;
  logic            armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_d1  <= '0;
      lat_lo <= '0;
      lo_run <= '0;
      armed  <= 1'b0;
    end else begin
      rd_d1 <= div_rdata;
      if (!enable) armed <= 1'b0;
      else if (fall_stb) armed <= 1'b1;
      if (fall_stb) begin
        lat_lo <= rd_d1[DW-1:0];
        lo_run <= 1;
      end else if (!scl_o) begin
        lo_run <= lo_run + 1'b1;
      end
    end
  end

  assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    div_we |=> div_rdata == $past(div_wdata));

  assert_low_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && armed && enable) |-> int'(lo_run) == (int'(lat_lo) + 1) * 8);

  assert_stretch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && scl_o && !scl_in) |=> (scl_o && !fall_stb));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_o && !fall_stb && !rise_stb && !lo_mid_stb && !hi_mid_stb));

  assert_fall_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!scl_o && $past(scl_o)));

  assert_rise_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (scl_o && !$past(scl_o)));

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_stb, rise_stb, lo_mid_stb, hi_mid_stb}));
endmodule

bind scl_divgen scl_divgen_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .div_we(div_we),
  .div_wdata(div_wdata), .div_rdata(div_rdata), .scl_in(scl_in),
  .scl_o(scl_o), .fall_stb(fall_stb), .rise_stb(rise_stb),
  .lo_mid_stb(lo_mid_stb), .hi_mid_stb(hi_mid_stb)
);

// File: tb/sim_scl_divgen.sv
`timescale 1ns/1ps
module sim_scl_divgen;
  localparam int DW = 8;

  typedef struct {
    int lo_len;
    int lo_mid;
    int hi_len;
    int hi_mid;
  } period_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic we = 1'b0;
  logic [2*DW-1:0] wdata = '0;
  logic stretch = 1'b0;
  logic [2*DW-1:0] rdata;
  logic scl_o, fall_stb, rise_stb, lo_mid_stb, hi_mid_stb;
  wire  scl_in = scl_o & ~stretch;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int t_f = 0, t_r = 0, m_lo = -1, m_hi = -1;
  bit have_f = 0, have_r = 0;
  period_t expq[$];

  always #10 clk = ~clk;

  scl_divgen #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(en), .div_we(we), .div_wdata(wdata),
    .div_rdata(rdata), .scl_in(scl_in), .scl_o(scl_o), .fall_stb(fall_stb),
    .rise_stb(rise_stb), .lo_mid_stb(lo_mid_stb), .hi_mid_stb(hi_mid_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int lo, input int hi, input int s);
    period_t p;
    p.lo_len = 8 * (lo + 1);
    p.lo_mid = 4 * (lo + 1);
    p.hi_len = 8 * (hi + 1) + s;
    p.hi_mid = 4 * (hi + 1) + s;
    expq.push_back(p);
  endtask

  task automatic write_div(input int lo, input int hi);
    logic [2*DW-1:0] v;
    v = {DW'(hi), DW'(lo)};
    @(posedge clk); #2 we = 1'b1; wdata = v;
    @(posedge clk); #2 we = 1'b0;
    @(negedge clk);
    check(rdata == v, "R1 readback", int'(rdata), int'(v));
  endtask

  task automatic start_run();
    @(posedge clk); #2 en = 1'b1;
    @(posedge clk); @(negedge clk);
    check(!scl_o && fall_stb, "R9 start latency", {scl_o, fall_stb}, 1);
  endtask

  task automatic stop_run();
    while (expq.size() != 0) @(negedge clk);
    @(posedge clk); #2 en = 1'b0;
    @(posedge clk); @(negedge clk);
    check(scl_o == 1'b1, "R8 release on disable", scl_o, 1);
  endtask

  // Monitor: measures each completed SCL period and compares it to the queue head (R2-R7)
  always @(negedge clk) begin
    cyc++;
    if (!en) begin
      have_f = 0;
      have_r = 0;
    end else begin
      if (lo_mid_stb && have_f) m_lo = cyc - t_f;
      if (hi_mid_stb && have_r) m_hi = cyc - t_r;
      if (rise_stb && have_f) begin
        check(scl_o == 1'b1, "R11 rise level", scl_o, 1);
        t_r = cyc;
        have_r = 1;
      end
      if (fall_stb) begin
        if (have_f && have_r) begin
          if (expq.size() == 0) begin
            check(0, "R6 unexpected period", cyc - t_f, 0);
          end else begin
            period_t e;
            e = expq.pop_front();
            check(t_r - t_f == e.lo_len, "R2 low length", t_r - t_f, e.lo_len);
            check(m_lo == e.lo_mid, "R4 low mid", m_lo, e.lo_mid);
            check(cyc - t_r == e.hi_len, "R3/R7 high length", cyc - t_r, e.hi_len);
            check(m_hi == e.hi_mid, "R5/R7 high mid", m_hi, e.hi_mid);
          end
        end
        t_f = cyc;
        have_f = 1;
        have_r = 0;
        m_lo = -1;
        m_hi = -1;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(scl_o && !fall_stb && !rise_stb && !lo_mid_stb && !hi_mid_stb,
          "R10 reset outputs", {scl_o, fall_stb, rise_stb, lo_mid_stb, hi_mid_stb}, 16);
    check(rdata == '0, "R10 reset divider", int'(rdata), 0);

    // Idle while disabled: no strobes, SCL released (R8)
    write_div(3, 4);
    begin
      bit quiet = 1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!scl_o || fall_stb || rise_stb || lo_mid_stb || hi_mid_stb) quiet = 0;
      end
      check(quiet, "R8 idle quiet", quiet, 1);
    end

    // Unequal phases, high longer
    repeat (3) push(3, 4, 0);
    start_run();
    stop_run();

    // Fastest setting, both fields zero
    write_div(0, 0);
    repeat (2) push(0, 0, 0);
    start_run();
    stop_run();

    // Low longer than high
    write_div(6, 1);
    repeat (2) push(6, 1, 0);
    start_run();
    stop_run();

    // New divider written mid-period applies at the next fall (R6)
    write_div(2, 2);
    push(2, 2, 0);
    start_run();
    write_div(0, 5);
    repeat (2) push(0, 5, 0);
    stop_run();

    // Target stretches the high phase by 5 cycles (R7)
    write_div(1, 2);
    push(1, 2, 5);
    push(1, 2, 0);
    start_run();
    do @(negedge clk); while (!rise_stb);
    @(posedge clk); #2 stretch = 1'b1;
    repeat (5) @(posedge clk);
    #2 stretch = 1'b0;
    stop_run();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule